// File: doc/BRIEF.md
# Transmit-Only Serial Peripheral Master

This block shifts frames of one or more bytes out to serial peripherals such as chained latched shift registers. It drives a data line, a serial clock and one select line. A frame is handed over on a valid/ready handshake. The frame's byte count is given with it, so several devices in a chain can be loaded in one select window. Data goes out most-significant bit first.

The clock mode is set by two plain settings: the level the serial clock rests at, and the edge on which the peripheral samples. Inside the block these are combined by XOR into a phase bit. That bit decides whether the first clock edge of the frame is a sampling edge or a shifting edge. The data line only changes on the edge that is not the sampling edge. The select level is programmable, and so are a setup gap before the first clock edge, a hold gap after the last one, and the serial clock's half period. Select stays active for the whole frame. The edge at which it is released is the moment the peripheral copies its shift stage into its output latch.

All settings are captured when a frame is accepted. Between frames the clock and select outputs show the live resting levels.

Top module: `spi_tx_master`

## Requirements
- R1: During and right after reset: `tx_ready` is 1, `spi_mosi` is 0, `spi_sclk` shows the `cfg_idle_lvl` input and `spi_sel` shows the inverse of `cfg_sel_high`.
- R2: While no frame is in progress, `spi_sclk` equals `cfg_idle_lvl`. At the end of every frame the serial clock is back at the idle level captured at acceptance.
- R3: With `cfg_sample_rise`=1 the peripheral samples on rising serial clock edges; with 0 it samples on falling edges. The internal phase is `cfg_idle_lvl` XOR `cfg_sample_rise`. `spi_mosi` never changes in the same cycle as a sampling edge.
- R4: With `tx_len`=L, the frame is the low 8*(L+1) bits of `tx_data`, sent from bit 8*(L+1)-1 down to bit 0. Higher bits of `tx_data` are ignored.
- R5: A frame has exactly 8*(L+1) sampling edges and 16*(L+1) serial clock transitions, all inside one select window. Select is not released at byte boundaries.
- R6: Select is active at level `cfg_sel_high` (1 = active high) from the cycle after acceptance until release. It stays stable during the frame and is inactive between frames.
- R7: The first serial clock transition comes `cfg_setup` + `cfg_div` + 1 cycles after select becomes active. A setup value of 0 is allowed.
- R8: Select is released `cfg_hold` + 1 cycles after the last serial clock transition. A hold value of 0 gives a single-cycle gap.
- R9: Serial clock transitions within a frame are spaced `cfg_div` + 1 system clock cycles apart.
- R10: A frame is accepted in a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is low from the next cycle until the cycle in which select returns to inactive, and is high again in that same cycle.
- R11: Changes to the configuration inputs, `tx_data` or `tx_len` while a frame is in progress have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idle_lvl | input | 1 | Resting level of the serial clock |
| cfg_sample_rise | input | 1 | 1: peripheral samples on rising edge, 0: on falling edge |
| cfg_sel_high | input | 1 | 1: select is active high, 0: active low |
| cfg_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| cfg_setup | input | DLY_W | Cycles between select assertion and the serial clock start |
| cfg_hold | input | DLY_W | Extra cycles between the last clock edge and select release |
| tx_valid | input | 1 | Frame offered |
| tx_ready | output | 1 | Block is idle and takes a frame |
| tx_data | input | BYTE_W*MAX_BYTES | Frame bits, right aligned |
| tx_len | input | clog2(MAX_BYTES) | Frame byte count minus one |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_sel | output | 1 | Peripheral select / latch strobe |

## Verification
The assertions assume that `tx_valid` may be held or dropped freely, and that the settings are captured only in the acceptance cycle. Outside a frame they expect nothing of the clock and select outputs except that those outputs follow the live inputs. Inside a frame, the checks on data stability and half-period spacing are tied to the captured mode and divider, so they do not depend on what the inputs do during that frame. The stimulus scrambles the resting clock level, the sampling edge, the divider, the delays and the frame inputs during some frames. It always leaves the select polarity fixed, so the bench's peripheral model still finds the start and end of each select window without ambiguity.

// File: rtl/spi_tx_pkg.sv
// Shared types for the transmit-only serial master.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package spi_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic idle_lvl;
        logic sample_rise;
        logic sel_high;
    } spi_mode_s;

    // 1 when the first (leading) clock edge of the frame is a sampling edge
    function automatic logic lead_samples(input spi_mode_s m);
        return m.idle_lvl ^ m.sample_rise;
    endfunction

endpackage

// File: rtl/spi_tx_divider.sv
// Half-period timer: pulses tick every (div+1) cycles while run is high.
// Assumes: div is stable while run is high; counter restarts whenever run drops.
module spi_tx_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // count cycles inside the current half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_tx_shreg.sv
// Frame shift register: loads a right-aligned frame, left-justifies it by
// its length, and presents the current top bit on the data line.
// Assumes: len counts bytes minus one; load and shift are never both high.
module spi_tx_shreg #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load,
    input  logic [BYTE_W*MAX_BYTES-1:0]           data,
    input  logic [$clog2(MAX_BYTES)-1:0]          len,
    input  logic                                  shift,
    output logic                                  mosi
);

    localparam int FRAME_W = BYTE_W * MAX_BYTES;
    localparam int LEN_W   = $clog2(MAX_BYTES);

    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] aligned;

    // place byte lane b of the input at lane b + unused lanes
    always_comb begin
        aligned = '0;
        for (int b = 0; b < MAX_BYTES; b++) begin
            if (b <= int'(len)) begin
                aligned[(b + MAX_BYTES - 1 - int'(len))*BYTE_W +: BYTE_W] =
                    data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // load a new frame or move the next bit to the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= aligned;
        end else if (shift) begin
            sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign mosi = sh_q[FRAME_W-1];

    logic unused_len_w;
    assign unused_len_w = (LEN_W > 0) ? 1'b0 : 1'b0;

endmodule

// File: rtl/spi_tx_seq.sv
// Frame sequencer: captures settings on acceptance, walks setup, shift and
// hold phases, counts serial clock transitions and owns the clock level.
// Assumes: tick comes from a divider that runs only in the shift phase.
module spi_tx_seq
    import spi_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int DIV_W     = 8,
    parameter int DLY_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_req,
    input  spi_mode_s                         cfg_mode,
    input  logic [DIV_W-1:0]                  cfg_div,
    input  logic [DLY_W-1:0]                  cfg_setup,
    input  logic [DLY_W-1:0]                  cfg_hold,
    input  logic [$clog2(MAX_BYTES)-1:0]      len,
    input  logic                              tick,
    output seq_state_e                        state_q,
    output logic                              accept,
    output spi_mode_s                         mode_q,
    output logic [DIV_W-1:0]                  div_q,
    output logic [$clog2(2*BYTE_W*MAX_BYTES)-1:0] edge_idx,
    output logic                              last_edge,
    output logic                              sclk_q
);

    localparam int FRAME_W = BYTE_W * MAX_BYTES;
    localparam int LEN_W   = $clog2(MAX_BYTES);
    localparam int EDGE_W  = $clog2(2 * FRAME_W);

    logic [DLY_W-1:0]  setup_q;
    logic [DLY_W-1:0]  hold_q;
    logic [DLY_W-1:0]  dly_q;
    logic [EDGE_W-1:0] last_idx_q;
    logic [EDGE_W-1:0] edge_q;

    // index of the final clock transition for a frame of len+1 bytes
    function automatic logic [EDGE_W-1:0] final_edge(input logic [LEN_W-1:0] l);
        int n;
        n = (int'(l) + 1) * 2 * BYTE_W - 1;
        return n[EDGE_W-1:0];
    endfunction

    assign accept    = start_req && (state_q == ST_IDLE);
    assign edge_idx  = edge_q;
    assign last_edge = (edge_q == last_idx_q);

    // capture the frame's settings in the acceptance cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            div_q      <= '0;
            setup_q    <= '0;
            hold_q     <= '0;
            last_idx_q <= '0;
        end else if (accept) begin
            mode_q     <= cfg_mode;
            div_q      <= cfg_div;
            setup_q    <= cfg_setup;
            hold_q     <= cfg_hold;
            last_idx_q <= final_edge(len);
        end
    end

    // phase machine with shared setup/hold delay counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dly_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    dly_q <= '0;
                    if (accept) begin
                        state_q <= (cfg_setup == '0) ? ST_SHIFT : ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (dly_q == setup_q - 1'b1) begin
                        state_q <= ST_SHIFT;
                        dly_q   <= '0;
                    end else begin
                        dly_q <= dly_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    dly_q <= '0;
                    if (tick && last_edge) begin
                        state_q <= ST_HOLD;
                    end
                end
                default: begin
                    if (dly_q == hold_q) begin
                        state_q <= ST_IDLE;
                        dly_q   <= '0;
                    end else begin
                        dly_q <= dly_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // count serial clock transitions within the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else if (accept) begin
            edge_q <= '0;
        end else if (tick && !last_edge) begin
            edge_q <= edge_q + 1'b1;
        end
    end

    // serial clock level: start at idle, flip on every tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else if (accept) begin
            sclk_q <= cfg_mode.idle_lvl;
        end else if (tick) begin
            sclk_q <= ~sclk_q;
        end
    end

endmodule

// File: rtl/spi_tx_master.sv
// Transmit-only serial master: accepts a 1..MAX_BYTES frame on valid/ready,
// holds select active across the whole frame, and clocks bits out MSB first
// with the clock mode chosen by idle level and sampling edge.
// Assumes: the peripheral latches its outputs on the select release edge.
module spi_tx_master
    import spi_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int DIV_W     = 8,
    parameter int DLY_W     = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_idle_lvl,
    input  logic                               cfg_sample_rise,
    input  logic                               cfg_sel_high,
    input  logic [DIV_W-1:0]                   cfg_div,
    input  logic [DLY_W-1:0]                   cfg_setup,
    input  logic [DLY_W-1:0]                   cfg_hold,
    input  logic                               tx_valid,
    output logic                               tx_ready,
    input  logic [BYTE_W*MAX_BYTES-1:0]        tx_data,
    input  logic [$clog2(MAX_BYTES)-1:0]       tx_len,
    output logic                               spi_sclk,
    output logic                               spi_mosi,
    output logic                               spi_sel
);

    localparam int FRAME_W = BYTE_W * MAX_BYTES;
    localparam int EDGE_W  = $clog2(2 * FRAME_W);

    seq_state_e        state_q;
    spi_mode_s         cfg_mode;
    spi_mode_s         mode_q;
    logic [DIV_W-1:0]  div_q;
    logic [EDGE_W-1:0] edge_idx;
    logic              accept;
    logic              tick;
    logic              last_edge;
    logic              sclk_q;
    logic              busy;
    logic              shift_en;

    assign cfg_mode = '{idle_lvl: cfg_idle_lvl,
                        sample_rise: cfg_sample_rise,
                        sel_high: cfg_sel_high};

    spi_tx_seq #(
        .BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .DIV_W(DIV_W), .DLY_W(DLY_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(tx_valid),
        .cfg_mode(cfg_mode), .cfg_div(cfg_div),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .len(tx_len),
        .tick(tick), .state_q(state_q), .accept(accept),
        .mode_q(mode_q), .div_q(div_q), .edge_idx(edge_idx),
        .last_edge(last_edge), .sclk_q(sclk_q)
    );

    spi_tx_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_SHIFT),
        .div(div_q), .tick(tick)
    );

    // move data only on the non-sampling transitions, never past the last bit
    always_comb begin
        if (lead_samples(mode_q)) begin
            shift_en = tick && edge_idx[0] && !last_edge;
        end else begin
            shift_en = tick && !edge_idx[0] && (edge_idx != '0);
        end
    end

    spi_tx_shreg #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_sh (
        .clk(clk), .rst_n(rst_n), .load(accept), .data(tx_data),
        .len(tx_len), .shift(shift_en), .mosi(spi_mosi)
    );

    assign busy     = (state_q != ST_IDLE);
    assign tx_ready = !busy;
    assign spi_sclk = busy ? sclk_q : cfg_idle_lvl;
    assign spi_sel  = busy ? mode_q.sel_high : !cfg_sel_high;

endmodule

// File: rtl/spi_tx_master_chk.sv
// Property checker for spi_tx_master, bound into every instance.
// Assumes: settings are meaningful only as captured at acceptance.
module spi_tx_master_chk
    import spi_tx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             cfg_sel_high,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic             spi_sel,
    input spi_mode_s        mode_q,
    input logic [DIV_W-1:0] div_q,
    input seq_state_e       state_q
);

    logic             sclk_d;
    logic             busy_d;
    logic             seen_tog;
    logic [DIV_W:0]   gap;
    logic             tog_now;

    assign tog_now = !tx_ready && busy_d && (spi_sclk != sclk_d);

    // track clock level and cycles since the previous transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            busy_d   <= 1'b0;
            seen_tog <= 1'b0;
            gap      <= '0;
        end else begin
            sclk_d <= spi_sclk;
            busy_d <= !tx_ready;
            if (tx_ready) begin
                seen_tog <= 1'b0;
                gap      <= '0;
            end else if (tog_now) begin
                seen_tog <= 1'b1;
                gap      <= '0;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);

    // R6
    sel_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_valid && tx_ready) |-> spi_sel == $past(cfg_sel_high));

    // R6
    sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && $past(!tx_ready)) |-> $stable(spi_sel));

    // R3
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && $past(!tx_ready) && spi_sclk != $past(spi_sclk)
         && spi_sclk == mode_q.sample_rise) |-> $stable(spi_mosi));

    // R2
    setup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> spi_sclk == mode_q.idle_lvl);

    // R9
    clk_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tog_now |-> $past(state_q) == ST_SHIFT);

    // R9
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_now && seen_tog) |-> gap == {1'b0, div_q});

endmodule

bind spi_tx_master spi_tx_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .cfg_sel_high(cfg_sel_high), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_sel(spi_sel), .mode_q(mode_q), .div_q(div_q), .state_q(state_q)
);

// File: tb/spi_tx_master_bench.sv
// Bench: a peripheral model watches the serial lines and records each frame;
// directed corners plus seeded random frames are compared with expectations.
module spi_tx_master_bench;

    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;
    localparam int DIV_W     = 8;
    localparam int DLY_W     = 8;
    localparam int FRAME_W   = BYTE_W * MAX_BYTES;
    localparam int LEN_W     = $clog2(MAX_BYTES);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cfg_idle_lvl = 1'b0;
    logic               cfg_sample_rise = 1'b1;
    logic               cfg_sel_high = 1'b0;
    logic [DIV_W-1:0]   cfg_div = '0;
    logic [DLY_W-1:0]   cfg_setup = '0;
    logic [DLY_W-1:0]   cfg_hold = '0;
    logic               tx_valid = 1'b0;
    logic               tx_ready;
    logic [FRAME_W-1:0] tx_data = '0;
    logic [LEN_W-1:0]   tx_len = '0;
    logic               spi_sclk, spi_mosi, spi_sel;

    spi_tx_master #(
        .BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .DIV_W(DIV_W), .DLY_W(DLY_W)
    ) u_spi_tx_master (
        .clk(clk), .rst_n(rst_n), .cfg_idle_lvl(cfg_idle_lvl),
        .cfg_sample_rise(cfg_sample_rise), .cfg_sel_high(cfg_sel_high),
        .cfg_div(cfg_div), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_len(tx_len), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_sel(spi_sel)
    );

    int checks = 0;
    int fails  = 0;

    // frame settings as the peripheral model knows them
    bit fr_idle = 1'b0, fr_rise = 1'b1, fr_selh = 1'b0;
    int fr_div = 0;

    // peripheral model state
    bit          prev_act = 1'b0, prev_sclk = 1'b0, prev_mosi = 1'b0;
    bit          first_tog, done, ready_at_rel, end_lvl;
    int          ctr, last_tog, tog_cnt, samp_cnt, setup_meas, hold_meas;
    int          bad_mosi, bad_half, bad_ready, starts = 0;
    logic [31:0] cap;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_bits(input logic [31:0] d, input int len);
        int nb;
        nb = (len + 1) * BYTE_W;
        return (nb >= 32) ? d : (d & ((32'd1 << nb) - 32'd1));
    endfunction

    // peripheral model: observe lines between clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            bit act;
            act = (spi_sel == fr_selh);
            if (act) begin
                if (!prev_act) begin
                    starts++; ctr = 0; last_tog = 0; tog_cnt = 0; samp_cnt = 0;
                    cap = '0; bad_mosi = 0; bad_half = 0; bad_ready = 0;
                    first_tog = 1'b1;
                end else begin
                    ctr++;
                    if (spi_sclk != prev_sclk) begin
                        if (first_tog) begin
                            setup_meas = ctr;
                            first_tog  = 1'b0;
                        end else if (ctr - last_tog != fr_div + 1) begin
                            bad_half++;
                        end
                        last_tog = ctr;
                        tog_cnt++;
                        if (spi_sclk == fr_rise) begin
                            cap = {cap[30:0], spi_mosi};
                            samp_cnt++;
                            if (spi_mosi != prev_mosi) bad_mosi++;
                        end
                    end
                end
                if (tx_ready) bad_ready++;
            end else if (prev_act) begin
                hold_meas    = ctr + 1 - last_tog;
                ready_at_rel = tx_ready;
                end_lvl      = prev_sclk;
                done         = 1'b1;
            end
            prev_act  = act;
            prev_sclk = spi_sclk;
            prev_mosi = spi_mosi;
        end
    end

    task automatic run_frame(input logic [31:0] data, input int len, input bit idle,
                             input bit rise, input bit selh, input int div,
                             input int setup, input int hold, input bit scr);
        int nb, t, st0;
        @(posedge clk); #2;
        cfg_idle_lvl = idle; cfg_sample_rise = rise; cfg_sel_high = selh;
        cfg_div = 8'(div); cfg_setup = 8'(setup); cfg_hold = 8'(hold);
        fr_idle = idle; fr_rise = rise; fr_selh = selh; fr_div = div;
        repeat (2) @(posedge clk);
        #2;
        chk(spi_sclk == idle, "R2 idle clock level", spi_sclk, idle);
        chk(spi_sel == !selh && tx_ready, "R6 R10 inactive select and ready",
            {spi_sel, tx_ready}, {!selh, 1'b1});
        st0  = starts;
        done = 1'b0;
        tx_valid = 1'b1; tx_data = data; tx_len = LEN_W'(len);
        @(posedge clk); #2;
        tx_valid = 1'b0;
        if (scr) begin
            cfg_idle_lvl = 1'($urandom); cfg_sample_rise = 1'($urandom);
            cfg_div = 8'($urandom_range(0, 7)); cfg_setup = 8'($urandom_range(0, 7));
            cfg_hold = 8'($urandom_range(0, 7)); tx_data = $urandom;
            tx_len = LEN_W'($urandom);
        end
        t = 0;
        while (!done && t < 5000) begin
            @(posedge clk); t++;
        end
        #2;
        nb = (len + 1) * BYTE_W;
        chk(done, "R10 frame completes", done, 1);
        if (scr)
            chk(cap == expect_bits(data, len), "R11 stream unaffected by mid-frame changes",
                cap, expect_bits(data, len));
        else
            chk(cap == expect_bits(data, len), "R4 MSB-first stream", cap, expect_bits(data, len));
        chk(samp_cnt == nb, "R5 sampling edge count", samp_cnt, nb);
        chk(tog_cnt == 2 * nb, "R5 clock transition count", tog_cnt, 2 * nb);
        chk(starts == st0 + 1, "R5 single select window", starts - st0, 1);
        chk(bad_mosi == 0, "R3 data stable at sampling edges", bad_mosi, 0);
        chk(setup_meas == setup + div + 1, "R7 setup gap", setup_meas, setup + div + 1);
        chk(bad_half == 0, "R9 half period spacing", bad_half, 0);
        chk(hold_meas == hold + 1, "R8 hold gap", hold_meas, hold + 1);
        chk(bad_ready == 0 && ready_at_rel, "R10 ready low in frame, high at release",
            {bad_ready[7:0], ready_at_rel}, 9'h001);
        chk(end_lvl == idle, "R2 clock back at idle", end_lvl, idle);
        if (scr) begin
            cfg_idle_lvl = idle; cfg_sample_rise = rise;
            cfg_div = 8'(div); cfg_setup = 8'(setup); cfg_hold = 8'(hold);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd1597);
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
        chk(spi_sel == 1'b1 && spi_sclk == 1'b0, "R1 select and clock in reset",
            {spi_sel, spi_sclk}, 2'b10);
        chk(spi_mosi == 1'b0, "R1 data line in reset", spi_mosi, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(tx_ready && spi_mosi == 1'b0, "R1 after reset release", {tx_ready, spi_mosi}, 2'b10);

        // directed corners: each clock mode, zero delays, upper bits ignored
        run_frame(32'h0000_00A5, 0, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0);
        run_frame(32'h0000_0080, 0, 1'b1, 1'b1, 1'b0, 1, 2, 1, 1'b0);
        run_frame(32'h0000_003C, 0, 1'b0, 1'b0, 1'b1, 2, 0, 3, 1'b0);
        run_frame(32'hDEAD_BEEF, 3, 1'b1, 1'b0, 1'b1, 0, 1, 0, 1'b0);
        run_frame(32'hFFFF_0001, 1, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0);
        run_frame(32'h1234_5678, 3, 1'b0, 1'b1, 1'b0, 3, 3, 3, 1'b1);
        run_frame(32'h8000_0001, 2, 1'b1, 1'b1, 1'b1, 0, 0, 0, 1'b1);

        // seeded random frames
        for (int i = 0; i < 30; i++) begin
            run_frame($urandom, int'($urandom_range(0, MAX_BYTES - 1)),
                      1'($urandom), 1'($urandom), 1'($urandom),
                      int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule